// File: doc/BRIEF.md
# Column-Addressed Configuration Frame Loader

This block turns a stream of 32-bit configuration words, arriving on a parallel port with a valid qualifier, into writes of a wordline/bitline style configuration memory spread over a tiled fabric. The memory has one horizontal group of 32 data lines per tile row and one vertical group of frame-select lines per tile column. The controller first waits for a fixed synchronisation word. It then reads a header that names one target column and which of that column's frames are to be written.

After the header, the block collects one data word for each tile row into a data register as tall as the fabric. The first word goes to the top row. When the last row word is in, the block pulses the header's frame-select bits on the chosen column for one clock. During that clock the full data register is already stable on the row lines. The next word is read as a new header. A header with its sync flag cleared sends the block back to searching for the synchronisation word. The row and column counts are parameters, each up to 32.

Top module: `cfg_frame_loader`

## Requirements
- R1: After a synchronous active-high reset, every column strobe line is low, every row data line is low, and the block is searching for the synchronisation word.
- R2: While searching, every word other than the synchronisation word (default 32'hA5C3_0F96) is discarded. Such words change neither the row data nor the strobes, even when they are shaped like a header followed by row words.
- R3: The word that follows the synchronisation word is a header. Bits [31:27] give the column number, bit [20] is the sync flag, and bits [19:0] are the frame-select field. Bits [26:21] have no effect.
- R4: After a header with the sync flag set, exactly N_ROWS data words are accepted. The k-th of these words, counting from 0, is placed on row_bits[k*32 +: 32]. Row 0 is the top row. The row data holds its value until it is overwritten.
- R5: In the clock after the last row word is accepted, col_strobe[c*20 +: 20] equals the header's frame-select field for the chosen column c. It stays at that value for exactly one clock and then returns to zero. The row data is unchanged during that clock.
- R6: While a column's strobes pulse, the strobes of every other column stay low.
- R7: The word that follows a completed frame is taken as the next header, so frames may follow each other without another synchronisation word.
- R8: A header with bit [20] clear writes nothing and returns the block to searching for the synchronisation word.
- R9: A header whose column number is N_COLS or more produces no strobe. The following N_ROWS words are still loaded into the row data, and the word after them is a header.
- R10: Clocks with word_valid low are ignored in every state. Gaps between the words of a frame do not change the outcome.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_valid | input | 1 | word_data carries a word this clock |
| word_data | input | 32 | Configuration word |
| row_bits | output | N_ROWS*32 | Frame data lines; row k on bits [k*32 +: 32] |
| col_strobe | output | N_COLS*20 | Frame-select lines; column c on bits [c*20 +: 20] |

## Verification
The first stimulus is a header-shaped frame sent before any synchronisation word. It separates a block that truly waits for the pattern from one that decodes every word. Frames are then sent back to back to several columns with different frame fields, including single-bit, all-ones and mixed fields. These show whether the right column and the right frames pulse, whether the pulse lasts exactly one clock, and whether the header that follows a frame is taken without a new synchronisation word. A frame with idle gaps between its words tests whether the row counter advances only on valid words. Out-of-range column numbers (5 and 31) show that row words are consumed but no strobe is issued. A header with the sync flag cleared, followed by a well-formed frame that must be dropped, shows the return to the search state.

// File: rtl/cfg_frame_pkg.sv
package cfg_frame_pkg;
  localparam int WORD_W   = 32;
  localparam int COLSEL_W = 5;
  localparam int FRAME_W  = 20;
  localparam int COLSEL_LSB = 27;
  localparam int LIVE_BIT   = 20;

  typedef enum logic [1:0] {
    ST_SEEK = 2'd0,
    ST_HDR  = 2'd1,
    ST_LOAD = 2'd2
  } ldr_state_e;
endpackage

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
  import cfg_frame_pkg::*;
#(
  parameter int          N_ROWS   = 4,
  parameter logic [31:0] SYNC_PAT = 32'hA5C3_0F96,
  localparam int         IDX_W    = (N_ROWS > 1) ? $clog2(N_ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic             hdr_take,
  output logic             row_wr,
  output logic [IDX_W-1:0] row_idx,
  output logic             frame_done
);
  ldr_state_e state_q;
  logic [IDX_W-1:0] idx_q;
  logic live;

  assign live       = word_data[LIVE_BIT];
  assign hdr_take   = word_valid && (state_q == ST_HDR) && live;
  assign row_wr     = word_valid && (state_q == ST_LOAD);
  assign row_idx    = idx_q;
  assign frame_done = row_wr && (idx_q == IDX_W'(N_ROWS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_SEEK;
      idx_q   <= '0;
    end else if (word_valid) begin
      case (state_q)
        ST_SEEK: if (word_data == SYNC_PAT) state_q <= ST_HDR;
        ST_HDR: begin
          idx_q   <= '0;
          state_q <= live ? ST_LOAD : ST_SEEK;
        end
        ST_LOAD: begin
          if (frame_done) begin
            idx_q   <= '0;
            state_q <= ST_HDR;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        default: state_q <= ST_SEEK;
      endcase
    end
  end
endmodule

// File: rtl/cfg_frame_reg.sv
module cfg_frame_reg
  import cfg_frame_pkg::*;
#(
  parameter int  N_ROWS = 4,
  localparam int IDX_W  = (N_ROWS > 1) ? $clog2(N_ROWS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     row_wr,
  input  logic [IDX_W-1:0]         row_idx,
  input  logic [WORD_W-1:0]        row_word,
  output logic [N_ROWS*WORD_W-1:0] row_bits
);
  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    logic [WORD_W-1:0] line_q;
    always_ff @(posedge clk) begin
      if (rst) line_q <= '0;
      else if (row_wr && (row_idx == IDX_W'(r))) line_q <= row_word;
    end
    assign row_bits[r*WORD_W +: WORD_W] = line_q;
  end
endmodule

// File: rtl/cfg_strobe_drv.sv
module cfg_strobe_drv
  import cfg_frame_pkg::*;
#(
  parameter int N_COLS = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      hdr_take,
  input  logic [COLSEL_W-1:0]       col_field,
  input  logic [FRAME_W-1:0]        frame_field,
  input  logic                      fire,
  output logic [N_COLS*FRAME_W-1:0] col_strobe
);
  logic [COLSEL_W-1:0] col_q;
  logic [FRAME_W-1:0]  frames_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q    <= '0;
      frames_q <= '0;
    end else if (hdr_take) begin
      col_q    <= col_field;
      frames_q <= frame_field;
    end
  end

  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    logic [FRAME_W-1:0] stb_q;
    always_ff @(posedge clk) begin
      if (rst) stb_q <= '0;
      else if (fire && (col_q == COLSEL_W'(c))) stb_q <= frames_q;
      else stb_q <= '0;
    end
    assign col_strobe[c*FRAME_W +: FRAME_W] = stb_q;
  end
endmodule

// File: rtl/cfg_frame_loader.sv
module cfg_frame_loader
  import cfg_frame_pkg::*;
#(
  parameter int          N_ROWS   = 4,
  parameter int          N_COLS   = 4,
  parameter logic [31:0] SYNC_PAT = 32'hA5C3_0F96,
  localparam int         IDX_W    = (N_ROWS > 1) ? $clog2(N_ROWS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         word_valid,
  input  logic [31:0]                  word_data,
  output logic [N_ROWS*32-1:0]         row_bits,
  output logic [N_COLS*20-1:0]         col_strobe
);
  logic             hdr_take;
  logic             row_wr;
  logic [IDX_W-1:0] row_idx;
  logic             frame_done;

  cfg_seq_fsm #(.N_ROWS(N_ROWS), .SYNC_PAT(SYNC_PAT)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .word_valid (word_valid),
    .word_data  (word_data),
    .hdr_take   (hdr_take),
    .row_wr     (row_wr),
    .row_idx    (row_idx),
    .frame_done (frame_done)
  );

  cfg_frame_reg #(.N_ROWS(N_ROWS)) u_rows (
    .clk      (clk),
    .rst      (rst),
    .row_wr   (row_wr),
    .row_idx  (row_idx),
    .row_word (word_data),
    .row_bits (row_bits)
  );

  cfg_strobe_drv #(.N_COLS(N_COLS)) u_stb (
    .clk         (clk),
    .rst         (rst),
    .hdr_take    (hdr_take),
    .col_field   (word_data[COLSEL_LSB +: COLSEL_W]),
    .frame_field (word_data[FRAME_W-1:0]),
    .fire        (frame_done),
    .col_strobe  (col_strobe)
  );
endmodule

// File: rtl/cfg_frame_loader_chk.sv
module cfg_frame_loader_chk #(
  parameter int N_ROWS = 4,
  parameter int N_COLS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 word_valid,
  input logic [N_ROWS*32-1:0] row_bits,
  input logic [N_COLS*20-1:0] col_strobe
);
  logic [N_COLS-1:0] col_busy;
  always_comb begin
    for (int c = 0; c < N_COLS; c++) col_busy[c] = |col_strobe[c*20 +: 20];
  end

  // R5: a strobe pulse lasts one clock
  p_pulse_width_r5: assert property (@(posedge clk) disable iff (rst)
    (|col_strobe) |=> (col_strobe == '0));

  // R6: never more than one column strobed
  p_one_column_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(col_busy));

  // R5: row data holds through the strobe clock
  p_data_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (|col_strobe) |=> $stable(row_bits));

  // R10: a strobe only follows an accepted word
  p_strobe_after_word_r10: assert property (@(posedge clk) disable iff (rst)
    (|col_strobe) |-> $past(word_valid));
endmodule

bind cfg_frame_loader cfg_frame_loader_chk #(.N_ROWS(N_ROWS), .N_COLS(N_COLS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .word_valid (word_valid),
  .row_bits   (row_bits),
  .col_strobe (col_strobe)
);

// File: tb/cfg_frame_loader_tb_top.sv
module cfg_frame_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;
  localparam int NC = 4;
  localparam logic [31:0] SYNC = 32'hA5C3_0F96;

  typedef struct packed {
    logic [NC*20-1:0] stb;
    logic [NR*32-1:0] rows;
  } sb_item_t;

  logic clk = 0, rst = 1, word_valid = 0;
  logic [31:0] word_data = '0;
  logic [NR*32-1:0] row_bits;
  logic [NC*20-1:0] col_strobe;

  int n_checks = 0, n_fail = 0;
  sb_item_t sb_q[$];
  logic [NR*32-1:0] last_rows = '0;
  bit done = 0;

  cfg_frame_loader #(.N_ROWS(NR), .N_COLS(NC), .SYNC_PAT(SYNC)) dut_i (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_data(word_data),
    .row_bits(row_bits), .col_strobe(col_strobe));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] w);
    word_valid = 1; word_data = w;
    @(negedge clk);
    word_valid = 0; word_data = 32'h0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // header with junk in the unused bits [26:21] (R3)
  task automatic send_frame(input int col, input logic [19:0] fld,
                            input logic [31:0] base, input bit expect_stb, input int gap);
    sb_item_t it;
    it.stb = '0; it.rows = '0;
    for (int r = 0; r < NR; r++) it.rows[r*32 +: 32] = base + 32'(r) * 32'h0101_0101;
    if (col < NC) it.stb[col*20 +: 20] = fld;
    if (expect_stb && col < NC) sb_q.push_back(it);
    if (expect_stb) last_rows = it.rows;
    put({5'(col), 6'h2A, 1'b1, fld});
    for (int r = 0; r < NR; r++) begin
      put(it.rows[r*32 +: 32]);
      if (gap > 0 && r < NR-1) idle(gap);
    end
  endtask

  // scoreboard monitor
  logic [NC*20-1:0] prev_stb = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (|prev_stb && |col_strobe) begin
        n_checks++; n_fail++;
        $display("FAIL R5 strobe wider than one clock actual=%0h expected=0", col_strobe);
      end
      if (|col_strobe) begin
        if (sb_q.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL R2/R8/R9 unexpected strobe actual=%0h expected=0", col_strobe);
        end else begin
          sb_item_t e;
          e = sb_q.pop_front();
          check("R5/R6 strobe vector", 256'(col_strobe), 256'(e.stb));
          check("R4 row data at strobe", 256'(row_bits), 256'(e.rows));
        end
      end
    end
    prev_stb = col_strobe;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    idle(4);
    rst = 0;
    @(negedge clk);
    check("R1 strobes after reset", 256'(col_strobe), 256'(0));
    check("R1 row data after reset", 256'(row_bits), 256'(0));

    // R2: header-shaped frame before any sync word
    send_frame(0, 20'h00003, 32'h1111_0000, 0, 0);
    idle(2);
    check("R2 rows untouched before sync", 256'(row_bits), 256'(0));

    put(SYNC);
    send_frame(0, 20'h00001, 32'h0000_0010, 1, 0);   // R4 R5
    send_frame(3, 20'hFFFFF, 32'h2000_0000, 1, 0);   // R7 back to back
    send_frame(1, 20'h80001, 32'h3000_0055, 1, 2);   // R10 gaps
    idle(3);
    check("R4 rows held after frame", 256'(row_bits), 256'(last_rows));

    // R9: column out of range
    send_frame(5, 20'h0000F, 32'h4000_0001, 0, 0);
    begin
      logic [NR*32-1:0] x;
      for (int r = 0; r < NR; r++) x[r*32 +: 32] = 32'h4000_0001 + 32'(r) * 32'h0101_0101;
      idle(1);
      check("R9 rows consumed for bad column", 256'(row_bits), 256'(x));
      last_rows = x;
    end
    send_frame(2, 20'h5A5A5, 32'h5000_0002, 1, 0);   // R9 next word is a header
    idle(2);

    // R8: header with sync flag clear
    put({5'd0, 6'd0, 1'b0, 20'hFFFFF});
    send_frame(0, 20'h00010, 32'h6000_0003, 0, 0);
    idle(2);
    check("R8 rows untouched after sync-clear header", 256'(row_bits), 256'(last_rows));

    put(SYNC);
    send_frame(31, 20'h00100, 32'h7000_0004, 0, 0);  // R9 top column number
    send_frame(0, 20'h0A0A0, 32'h8000_0005, 1, 0);
    idle(4);
    check("R5 all expected strobes seen", 256'(sb_q.size()), 256'(0));
    check("R5 strobes low at end", 256'(col_strobe), 256'(0));

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule